// File: doc/BRIEF.md
# CSR Read-Modify-Write Execute Unit

This unit carries out the six control-and-status-register operations of a 32-bit RISC-V-style core in a single cycle. It takes an instruction word, the operand already fetched from the integer register file and the current program counter. It sends combinational read and write strobes to an external CSR file. It also returns a register-file write request and the sequential next PC.

Three operation kinds exist: swap, bit-set and bit-clear. Each comes in two operand flavours: a register value, or a 5-bit immediate taken from the source-index field. The instruction fields decide whether the CSR is actually read or written. This matters for CSRs whose read or write has side effects.

Some CSR files cannot accept a read or a write in a given cycle, so the unit raises those strobes only when the access really happens. The CSR data read in a cycle is the old value. The CSR write, the register write and the PC update all take effect at the receivers on the same rising clock edge. An issue strobe marks the cycles in which the unit executes.

Top module: `csr_exec_unit`

## Requirements
- R1: An issued word is handled when bits 6:0 equal 7'h73 and bits 14:12 (the function code) are 1, 2, 3, 5, 6 or 7. Otherwise `not_handled_o` is high and every strobe and enable is low.
- R2: The destination index is bits 11:7. The source index or immediate is bits 19:15. The CSR address, driven on both address outputs, is bits 31:20.
- R3: Function code 1 (register swap) with a nonzero destination reads the CSR and writes it with the register operand.
- R4: Function code 1 with destination index 0 writes the CSR with the register operand, raises no CSR read and raises no register write.
- R5: Function code 2 writes old OR operand. Function code 3 writes old AND NOT operand.
- R6: For function codes 2 and 3 with source index 0, the CSR is read but not written.
- R7: Function codes 5, 6 and 7 use bits 19:15 zero-extended to 32 bits as the operand, with swap, set and clear semantics in that order. Code 5 always reads and always writes the CSR.
- R8: For function codes 6 and 7 with an immediate of 0, the CSR is read but not written.
- R9: Whenever the CSR is read and the destination index is nonzero, the register file is written with the old CSR value. Destination index 0 never produces a register write.
- R10: `next_pc_o` is always `pc_i + 4`, modulo 2^32.
- R11: With `exec_valid_i` low, no strobe, enable or `not_handled_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid_i | input | 1 | Instruction issued this cycle |
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Source register value |
| pc_i | input | 32 | Current PC |
| csr_re_o | output | 1 | CSR read strobe |
| csr_raddr_o | output | 12 | CSR read address |
| csr_rdata_i | input | 32 | CSR read data (old value) |
| csr_we_o | output | 1 | CSR write strobe |
| csr_waddr_o | output | 12 | CSR write address |
| csr_wdata_o | output | 32 | CSR write data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_idx_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Register-file write data |
| next_pc_o | output | 32 | PC + 4 |
| not_handled_o | output | 1 | Issued word is not a CSR operation |

## Verification
The bench targets swap with destination x0, where a design that reads anyway would trigger read side effects. It also targets set and clear forms with a zero source index or zero immediate; a design that writes anyway would disturb CSR state.

Immediate forms use immediate values with bit 4 set, which exposes sign extension instead of zero extension. Function codes 0 and 4, and a wrong low opcode, check that a loose decoder does not fire strobes. A PC of 32'hFFFF_FFFC checks wrap-around.

The bench drives a poison value on the read data whenever no read is strobed. A design that forwards read data without a real read would then write that poison value to the register file.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

  localparam int unsigned INSN_W  = 32;
  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned IDX_W   = 5;
  localparam logic [6:0]  SYS_OPC = 7'h73;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SWAP = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic              hit;
    logic              use_imm;
    csr_op_e           op;
    logic [IDX_W-1:0]  dst;
    logic [IDX_W-1:0]  src;
    logic [CSR_AW-1:0] addr;
  } csr_dec_t;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_exec_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output csr_dec_t          dec_o
);
  localparam int unsigned DST_LO = 7;
  localparam int unsigned F3_LO  = 12;
  localparam int unsigned SRC_LO = 15;
  localparam int unsigned CSR_LO = 20;

  logic [2:0] fcode;
  logic       opc_ok;

  always_comb begin
    fcode         = instr_i[F3_LO +: 3];
    opc_ok        = (instr_i[6:0] == SYS_OPC);
    dec_o.hit     = opc_ok && (fcode[1:0] != 2'b00);
    dec_o.use_imm = fcode[2];
    dec_o.op      = dec_o.hit ? csr_op_e'(fcode[1:0]) : OP_NONE;
    dec_o.dst     = instr_i[DST_LO +: IDX_W];
    dec_o.src     = instr_i[SRC_LO +: IDX_W];
    dec_o.addr    = instr_i[CSR_LO +: CSR_AW];
  end
endmodule

// File: rtl/csr_access_ctrl.sv
module csr_access_ctrl
  import csr_exec_pkg::*;
(
  input  logic     valid_i,
  input  csr_dec_t dec_i,
  output logic     rd_en_o,
  output logic     wr_en_o,
  output logic     rf_en_o,
  output logic     nh_o
);
  logic dst_zero;
  logic src_zero;

  always_comb begin
    dst_zero = (dec_i.dst == '0);
    src_zero = (dec_i.src == '0);
    nh_o     = valid_i && !dec_i.hit;
    rd_en_o  = 1'b0;
    wr_en_o  = 1'b0;
    if (valid_i && dec_i.hit) begin
      unique case (dec_i.op)
        OP_SWAP: begin
          rd_en_o = dec_i.use_imm || !dst_zero;
          wr_en_o = 1'b1;
        end
        OP_SET, OP_CLR: begin
          rd_en_o = 1'b1;
          wr_en_o = !src_zero;
        end
        default: begin
          rd_en_o = 1'b0;
          wr_en_o = 1'b0;
        end
      endcase
    end
    rf_en_o = rd_en_o && !dst_zero;
  end
endmodule

// File: rtl/csr_update_alu.sv
module csr_update_alu
  import csr_exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  csr_op_e          op_i,
  input  logic             use_imm_i,
  input  logic [IDX_W-1:0] imm_i,
  input  logic [XLEN-1:0]  reg_val_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  new_o
);
  localparam int unsigned PAD_W = XLEN - IDX_W;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] operand;

  generate
    if (PAD_W > 0) begin : g_zext
      assign imm_ext = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    operand = use_imm_i ? imm_ext : reg_val_i;
    unique case (op_i)
      OP_SWAP: new_o = operand;
      OP_SET:  new_o = old_i | operand;
      OP_CLR:  new_o = old_i & ~operand;
      default: new_o = '0;
    endcase
  end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csr_exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_valid_i,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              csr_re_o,
  output logic [CSR_AW-1:0] csr_raddr_o,
  input  logic [XLEN-1:0]   csr_rdata_i,
  output logic              csr_we_o,
  output logic [CSR_AW-1:0] csr_waddr_o,
  output logic [XLEN-1:0]   csr_wdata_o,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              not_handled_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  csr_dec_t        dec;
  logic            rd_en;
  logic            wr_en;
  logic            rf_en;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;

  csr_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  csr_access_ctrl u_ctrl (
    .valid_i (exec_valid_i),
    .dec_i   (dec),
    .rd_en_o (rd_en),
    .wr_en_o (wr_en),
    .rf_en_o (rf_en),
    .nh_o    (not_handled_o)
  );

  assign old_val = rd_en ? csr_rdata_i : '0;

  csr_update_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (dec.op),
    .use_imm_i (dec.use_imm),
    .imm_i     (dec.src),
    .reg_val_i (src_val_i),
    .old_i     (old_val),
    .new_o     (new_val)
  );

  assign csr_re_o    = rd_en;
  assign csr_raddr_o = dec.addr;
  assign csr_we_o    = wr_en;
  assign csr_waddr_o = dec.addr;
  assign csr_wdata_o = wr_en ? new_val : '0;
  assign rf_we_o     = rf_en;
  assign rf_idx_o    = dec.dst;
  assign rf_wdata_o  = rf_en ? old_val : '0;
  assign next_pc_o   = pc_i + PC_STEP;

  AST_NH_QUIET: assert property (@(posedge clk) disable iff (rst)
    not_handled_o |-> (!csr_re_o && !csr_we_o && !rf_we_o)); // R1
  AST_SWAP_X0_NOREAD: assert property (@(posedge clk) disable iff (rst)
    (exec_valid_i && instr_i[6:0] == 7'h73 && instr_i[14:12] == 3'd1 && instr_i[11:7] == 5'd0)
    |-> (!csr_re_o && !rf_we_o)); // R4
  AST_SETCLR_ZERO_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (exec_valid_i && instr_i[6:0] == 7'h73 && instr_i[13] && instr_i[19:15] == 5'd0)
    |-> (!csr_we_o && csr_re_o)); // R6
  AST_RF_GETS_OLD: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (csr_re_o && rf_idx_o != 5'd0 && rf_wdata_o == csr_rdata_i)); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    exec_valid_i |-> (next_pc_o == pc_i + 32'd4)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !exec_valid_i |-> (!csr_re_o && !csr_we_o && !rf_we_o && !not_handled_o)); // R11
endmodule

// File: tb/csr_exec_unit_tb.sv
`timescale 1ns/1ps
module csr_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] srcv = 32'h0;
  logic [31:0] pc = 32'h0;
  logic        csr_re, csr_we, rf_we, nh;
  logic [11:0] raddr, waddr;
  logic [31:0] rdata, wdata, rf_wdata, npc;
  logic [4:0]  rf_idx;
  logic [31:0] mem [16];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  assign rdata = csr_re ? mem[raddr[3:0]] : 32'hDEAD_BEEF;

  csr_exec_unit u_dut (
    .clk(clk), .rst(rst), .exec_valid_i(valid), .instr_i(instr),
    .src_val_i(srcv), .pc_i(pc), .csr_re_o(csr_re), .csr_raddr_o(raddr),
    .csr_rdata_i(rdata), .csr_we_o(csr_we), .csr_waddr_o(waddr),
    .csr_wdata_o(wdata), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
    .rf_wdata_o(rf_wdata), .next_pc_o(npc), .not_handled_o(nh)
  );

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [4:0] s, input logic [11:0] a);
    return {a, s, f3, rd, 7'h73};
  endfunction

  function automatic string pick_tag(input logic [31:0] w);
    logic [2:0] f = w[14:12];
    if (w[6:0] != 7'h73 || f == 3'd0 || f == 3'd4) return "R1";
    if (f == 3'd1) return (w[11:7] == 0) ? "R4" : "R3";
    if (f == 3'd5) return "R7";
    if (f[2] == 1'b0) return (w[19:15] == 0) ? "R6" : "R5";
    return (w[19:15] == 0) ? "R8" : "R7";
  endfunction

  task automatic run_one(input bit v, input logic [31:0] w, input logic [31:0] s,
                         input logic [31:0] p, input string tag);
    logic [2:0]  f;
    logic        hit, e_re, e_we, e_rf, e_nh;
    logic [31:0] old, opnd, e_wd, e_rd;
    logic [128:0] act, exp;
    @(negedge clk);
    valid = v; instr = w; srcv = s; pc = p;
    #1;
    f    = w[14:12];
    hit  = v && w[6:0] == 7'h73 && f != 3'd0 && f != 3'd4;
    e_nh = v && !hit;
    old  = mem[w[23:20]];
    opnd = f[2] ? {27'd0, w[19:15]} : s;
    e_re = 0; e_we = 0; e_wd = 0;
    if (hit) begin
      case (f[1:0])
        2'd1: begin e_re = f[2] || (w[11:7] != 0); e_we = 1; e_wd = opnd; end
        2'd2: begin e_re = 1; e_we = (w[19:15] != 0); e_wd = old | opnd; end
        default: begin e_re = 1; e_we = (w[19:15] != 0); e_wd = old & ~opnd; end
      endcase
    end
    e_rf = e_re && (w[11:7] != 0);
    e_rd = e_rf ? old : 32'd0;
    exp = {e_re, e_re ? w[31:20] : 12'd0, e_we, e_we ? w[31:20] : 12'd0,
           e_we ? e_wd : 32'd0, e_rf, e_rf ? w[11:7] : 5'd0, e_rd, e_nh, p + 32'd4};
    act = {csr_re, csr_re ? raddr : 12'd0, csr_we, csr_we ? waddr : 12'd0,
           csr_we ? wdata : 32'd0, rf_we, rf_we ? rf_idx : 5'd0,
           rf_we ? rf_wdata : 32'd0, nh, npc};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: word %h got %h expected %h", tag, w, act, exp);
    end
    @(posedge clk);
    if (e_we) mem[w[23:20]] = e_wd;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 + i;
    repeat (3) @(posedge clk);
    run_one(0, mk(3'd1, 5'd3, 5'd2, 12'h001), 32'h1, 32'h100, "R11"); // reset state
    rst = 0;
    run_one(0, mk(3'd2, 5'd7, 5'd4, 12'h002), 32'hFF, 32'h200, "R11");
    run_one(1, mk(3'd1, 5'd9, 5'd6, 12'h345), 32'h1234_5678, 32'h300, "R2");
    run_one(1, mk(3'd1, 5'd0, 5'd6, 12'h346), 32'hCAFE_F00D, 32'h304, "R4");
    mem[4'h7] = 32'h0F0F_0000;
    run_one(1, mk(3'd2, 5'd1, 5'd2, 12'h007), 32'h0000_00FF, 32'h308, "R5");
    run_one(1, mk(3'd3, 5'd1, 5'd2, 12'h007), 32'h0F00_000F, 32'h30C, "R5");
    run_one(1, mk(3'd2, 5'd5, 5'd0, 12'h008), 32'hFFFF_FFFF, 32'h310, "R6");
    run_one(1, mk(3'd3, 5'd0, 5'd0, 12'h008), 32'hFFFF_FFFF, 32'h314, "R6");
    run_one(1, mk(3'd5, 5'd0, 5'd31, 12'h009), 32'h0, 32'h318, "R7");
    run_one(1, mk(3'd6, 5'd2, 5'd16, 12'h00A), 32'h0, 32'h31C, "R7");
    run_one(1, mk(3'd7, 5'd2, 5'd17, 12'h00A), 32'h0, 32'h320, "R7");
    run_one(1, mk(3'd6, 5'd2, 5'd0, 12'h00B), 32'h0, 32'h324, "R8");
    run_one(1, mk(3'd7, 5'd0, 5'd0, 12'h00B), 32'h0, 32'h328, "R8");
    run_one(1, mk(3'd3, 5'd31, 5'd3, 12'h00C), 32'h1, 32'h32C, "R9");
    run_one(1, mk(3'd0, 5'd4, 5'd3, 12'h00C), 32'h1, 32'h330, "R1");
    run_one(1, mk(3'd4, 5'd4, 5'd3, 12'h00C), 32'h1, 32'h334, "R1");
    run_one(1, mk(3'd1, 5'd4, 5'd3, 12'h00C) ^ 32'h1, 32'h1, 32'h338, "R1");
    run_one(1, mk(3'd2, 5'd4, 5'd3, 12'h00D), 32'h1, 32'hFFFF_FFFC, "R10");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 7) != 0) w[6:0] = 7'h73;
      if ($urandom_range(0, 3) == 0) w[11:7] = 5'd0;
      if ($urandom_range(0, 3) == 0) w[19:15] = 5'd0;
      run_one(1, w, $urandom, $urandom, pick_tag(w));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule